// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of binary token flags shared by two independent processor ports, called left and right. It has no memory array. Each port has its own select, a flag index, a one-bit write value, a write strobe and a one-bit read value. A port asks for a token by writing 0 to a flag. It then reads the same flag back: a 0 means the port now owns the token, and a 1 means it does not.

Each flag is a small state machine. The states are FREE, L_HELD, R_HELD, L_HELD_R_WAIT (left owns, right waits) and R_HELD_L_WAIT (right owns, left waits). The transitions are:

- claim: FREE to a HELD state.
- tie: FREE to L_HELD_R_WAIT, when both ports request in the same cycle.
- queue: HELD to HELD_WAIT, when the non-owner requests.
- handover: HELD_WAIT to the other side's HELD, when the owner writes 1.
- withdraw: HELD_WAIT back to HELD, when the waiting side writes 1.
- release: HELD to FREE, or HELD_WAIT to FREE when the owner releases and the waiter withdraws in the same cycle.

The flags do not guard anything in hardware, and a port never waits for an access to finish.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is FREE and nothing is pending, so both ports read 1 from every index.
- R2: When a port writes 0 to a FREE flag, that port reads 0 from that flag from the next clock edge, and the other port reads 1.
- R3: When a port writes 0 to a flag the other port owns, the requester keeps reading 1 and the owner keeps reading 0.
- R4: When both ports write 0 to the same FREE flag in the same cycle, the left port wins and the right port's request becomes pending.
- R5: When the owner writes 1 to a flag while the other port's request is pending, the other port owns the flag from the next edge and reads 0.
- R6: When the owner writes 1 to a flag with nothing pending, the flag becomes FREE.
- R7: When the pending port writes 1, its request is withdrawn, and a later release by the owner leaves the flag FREE.
- R8: An access to one flag index leaves every other flag unchanged.
- R9: A write is ignored when the port's select is low or its write strobe is low.
- R10: A port whose select is low reads 1.
- R11: When the owner writes 0 again, or a port that neither owns nor waits writes 1, the flag does not change.
- R12: The read value shows the flag's state in the same cycle the port selects it. A write shows up only from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port selects the bank |
| l_idx | input | IDX_W | Left port flag index |
| l_wr | input | 1 | Left write strobe |
| l_wdat | input | 1 | Left write value: 0 requests, 1 releases or withdraws |
| l_rdat | output | 1 | Left read value: 0 when the left port owns the indexed flag |
| r_sel | input | 1 | Right port selects the bank |
| r_idx | input | IDX_W | Right port flag index |
| r_wr | input | 1 | Right write strobe |
| r_wdat | input | 1 | Right write value: 0 requests, 1 releases or withdraws |
| r_rdat | output | 1 | Right read value: 0 when the right port owns the indexed flag |

## Verification
The hardest states to reach are the two waiting states. The bench has to land a request on a flag that is already held, or line up both ports on the same free flag in the same clock cycle. The stimulus drives both ports inside one clock low phase, so writes from the two sides meet at exactly one edge. It then either releases from the owner, to prove the handover, or withdraws from the waiter first, to prove the later release leaves the flag free.

// File: rtl/sem_pkg.sv
`timescale 1ns/1ps
package sem_pkg;
    typedef enum logic [2:0] {
        ST_FREE          = 3'd0,
        ST_L_HELD        = 3'd1,
        ST_R_HELD        = 3'd2,
        ST_L_HELD_R_WAIT = 3'd3,
        ST_R_HELD_L_WAIT = 3'd4
    } flag_state_e;
endpackage

// File: rtl/sem_port_dec.sv
`timescale 1ns/1ps
// Turns one port's access into per-flag request and release strobes.
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wr,
    input  logic                 wdat,
    output logic [NUM_FLAGS-1:0] req_o,
    output logic [NUM_FLAGS-1:0] rel_o
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic hit;
        assign hit      = sel && wr && (idx == IDX_W'(g));
        assign req_o[g] = hit && !wdat;
        assign rel_o[g] = hit && wdat;
    end
endmodule

// File: rtl/sem_flag_fsm.sv
`timescale 1ns/1ps
// One token flag: owner plus an optional waiting requester.
module sem_flag_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (l_req && r_req) state_d = ST_L_HELD_R_WAIT;
                else if (l_req)     state_d = ST_L_HELD;
                else if (r_req)     state_d = ST_R_HELD;
            end
            ST_L_HELD: begin
                if (l_rel)      state_d = r_req ? ST_R_HELD : ST_FREE;
                else if (r_req) state_d = ST_L_HELD_R_WAIT;
            end
            ST_R_HELD: begin
                if (r_rel)      state_d = l_req ? ST_L_HELD : ST_FREE;
                else if (l_req) state_d = ST_R_HELD_L_WAIT;
            end
            ST_L_HELD_R_WAIT: begin
                if (l_rel && r_rel) state_d = ST_FREE;
                else if (l_rel)     state_d = ST_R_HELD;
                else if (r_rel)     state_d = ST_L_HELD;
            end
            ST_R_HELD_L_WAIT: begin
                if (l_rel && r_rel) state_d = ST_FREE;
                else if (r_rel)     state_d = ST_L_HELD;
                else if (l_rel)     state_d = ST_R_HELD;
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_comb begin
        own_l  = 1'b0;
        own_r  = 1'b0;
        pend_l = 1'b0;
        pend_r = 1'b0;
        unique case (state_q)
            ST_FREE:          ;
            ST_L_HELD:        own_l = 1'b1;
            ST_R_HELD:        own_r = 1'b1;
            ST_L_HELD_R_WAIT: begin own_l = 1'b1; pend_r = 1'b1; end
            ST_R_HELD_L_WAIT: begin own_r = 1'b1; pend_l = 1'b1; end
            default:          ;
        endcase
    end
endmodule

// File: rtl/sem_read_mux.sv
`timescale 1ns/1ps
// Read path of one port: 0 only when the port owns the indexed flag.
module sem_read_mux #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] own,
    output logic                 rdat
);
    assign rdat = sel ? ~own[idx] : 1'b1;
endmodule

// File: rtl/sem_bank.sv
`timescale 1ns/1ps
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wr,
    input  logic             l_wdat,
    output logic             l_rdat,
    input  logic             r_sel,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wr,
    input  logic             r_wdat,
    output logic             r_rdat
);
    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_FLAGS-1:0] own_l, own_r, pend_l, pend_r;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_l (
        .sel(l_sel), .idx(l_idx), .wr(l_wr), .wdat(l_wdat),
        .req_o(l_req), .rel_o(l_rel)
    );
    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_r (
        .sel(r_sel), .idx(r_idx), .wr(r_wr), .wdat(r_wdat),
        .req_o(r_req), .rel_o(r_rel)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .own_l(own_l[g]), .own_r(own_r[g]),
            .pend_l(pend_l[g]), .pend_r(pend_r[g])
        );
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_rd_l (
        .sel(l_sel), .idx(l_idx), .own(own_l), .rdat(l_rdat)
    );
    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_rd_r (
        .sel(r_sel), .idx(r_idx), .own(own_r), .rdat(r_rdat)
    );
endmodule

// File: rtl/sem_bank_chk.sv
`timescale 1ns/1ps
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel,
    input logic [IDX_W-1:0]     l_idx,
    input logic                 l_wr,
    input logic                 l_wdat,
    input logic                 r_sel,
    input logic [IDX_W-1:0]     r_idx,
    input logic                 r_wr,
    input logic                 r_wdat,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r,
    input logic [NUM_FLAGS-1:0] pend_r
);
    logic l_rq, l_rl, r_rq, r_rl;
    assign l_rq = l_sel && l_wr && !l_wdat;
    assign l_rl = l_sel && l_wr && l_wdat;
    assign r_rq = r_sel && r_wr && !r_wdat;
    assign r_rl = r_sel && r_wr && r_wdat;

    AST_FREE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rq && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]); // R2

    AST_HELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rq && own_r[l_idx] && !r_rl) |=> (own_r[$past(l_idx)] && !own_l[$past(l_idx)])); // R3

    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rq && r_rq && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
        |=> (own_l[$past(l_idx)] && pend_r[$past(l_idx)])); // R4

    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rl && own_l[l_idx] && pend_r[l_idx] && !(r_rl && r_idx == l_idx))
        |=> own_r[$past(l_idx)]); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel && !r_sel) |=> ($stable(own_l) && $stable(own_r))); // R9
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_idx(l_idx), .l_wr(l_wr), .l_wdat(l_wdat),
    .r_sel(r_sel), .r_idx(r_idx), .r_wr(r_wr), .r_wdat(r_wdat),
    .own_l(own_l), .own_r(own_r), .pend_r(pend_r)
);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 0, l_wr = 0, l_wdat = 1;
    logic [2:0] l_idx = 0;
    logic       r_sel = 0, r_wr = 0, r_wdat = 1;
    logic [2:0] r_idx = 0;
    logic       l_rdat, r_rdat;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic       port;   // 0 left, 1 right
        logic       exp;
        logic [7:0] req;
    } item_t;
    item_t sb_q[$];
    event  tick;

    always #10 clk = ~clk; // 50 MHz

    sem_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_idx(l_idx), .l_wr(l_wr), .l_wdat(l_wdat), .l_rdat(l_rdat),
        .r_sel(r_sel), .r_idx(r_idx), .r_wr(r_wr), .r_wdat(r_wdat), .r_rdat(r_rdat)
    );

    // Monitor: pops expected items and compares them with the read ports.
    initial begin
        forever begin
            @(tick);
            while (sb_q.size() > 0) begin
                item_t it;
                logic  act;
                it  = sb_q.pop_front();
                act = it.port ? r_rdat : l_rdat;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL R%0d %s port: actual %b expected %b",
                             it.req, it.port ? "right" : "left", act, it.exp);
                end
            end
        end
    end

    // Driver: one cycle of both ports; optionally pushes expected reads
    // (sampled in the low phase, before the edge that applies the write).
    task automatic cyc(input logic ls, input logic [2:0] li, input logic lw, input logic ld,
                       input logic rs, input logic [2:0] ri, input logic rw, input logic rd,
                       input bit chk, input logic el, input logic er, input logic [7:0] req);
        @(negedge clk);
        l_sel = ls; l_idx = li; l_wr = lw; l_wdat = ld;
        r_sel = rs; r_idx = ri; r_wr = rw; r_wdat = rd;
        if (chk) begin
            sb_q.push_back('{port: 1'b0, exp: el, req: req});
            sb_q.push_back('{port: 1'b1, exp: er, req: req});
            #5;
            ->tick;
            #1;
        end
    endtask

    task automatic probe(input logic [2:0] li, input logic [2:0] ri,
                         input logic el, input logic er, input logic [7:0] req);
        cyc(1, li, 0, 1, 1, ri, 0, 1, 1, el, er, req);
    endtask

    task automatic wr_l(input logic [2:0] i, input logic d);
        cyc(1, i, 1, d, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic wr_r(input logic [2:0] i, input logic d);
        cyc(0, 0, 0, 1, 1, i, 1, d, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 8; i++) probe(3'(i), 3'(i), 1, 1, 1); // R1

        // R12: during the claiming cycle the read still shows FREE
        cyc(1, 2, 1, 0, 1, 2, 0, 1, 1, 1, 1, 12);
        probe(2, 2, 0, 1, 2);                 // R2 left owns 2
        wr_r(5, 0);
        probe(5, 5, 1, 0, 2);                 // R2 right owns 5
        probe(7, 4, 1, 1, 8);                 // R8 neighbours untouched

        wr_r(2, 0);                           // R3 request against left owner
        probe(2, 2, 0, 1, 3);
        wr_l(2, 1);                           // R5 handover to waiting right
        probe(2, 2, 1, 0, 5);
        wr_r(2, 1);                           // R6 release with nothing pending
        probe(2, 2, 1, 1, 6);
        probe(5, 5, 1, 0, 8);                 // R8 flag 5 still right's
        wr_r(5, 1);
        probe(5, 5, 1, 1, 6);

        cyc(1, 3, 1, 0, 1, 3, 1, 0, 0, 0, 0, 0); // R4 tie on flag 3
        probe(3, 3, 0, 1, 4);
        wr_l(3, 1);
        probe(3, 3, 1, 0, 4);                 // R4 right was pending
        wr_r(3, 1);

        wr_l(4, 0);                           // R7 withdraw
        wr_r(4, 0);
        wr_r(4, 1);
        probe(4, 4, 0, 1, 7);
        wr_l(4, 1);
        probe(4, 4, 1, 1, 7);

        cyc(0, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0); // R9 select low
        probe(1, 1, 1, 1, 9);
        cyc(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0); // R9 strobe low
        probe(1, 1, 1, 1, 9);

        wr_l(6, 0);
        wr_r(6, 1);                           // R11 stray release
        wr_l(6, 0);                           // R11 repeat request
        probe(6, 6, 0, 1, 11);
        cyc(0, 6, 0, 1, 1, 6, 0, 1, 1, 1, 1, 10); // R10 unselected left reads 1
        wr_l(6, 1);
        probe(6, 6, 1, 1, 11);

        cyc(0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule